// File: doc/BRIEF.md
# Out-of-Order Store Commit Scheduler

This block holds retired stores between the end of the pipeline and the L1 data cache. Each store takes the next slot of a ring at allocation time, so a slot's distance from the head gives its age. A later pulse marks the store as graduated, which means its instruction has retired. Graduation lets the store be written to the cache but does not write it. In each cycle the block looks at every graduated, uncommitted piece of a store. A piece is a candidate when the cache line it writes is held with write ownership, the piece sits behind no open fence, and it overlaps no byte that an older store still has to write. The oldest candidate is offered on a byte-masked, line-wide commit port.

A store that runs past the end of a line is tracked as two halves. Each half has its own line, byte mask and committed flag, so the half on an owned line can commit while the other half waits. A fence entry carries no data. It prevents every younger store from committing until every store older than the fence has finished. Slots are released only from the head, one per cycle, once the head has graduated and has nothing left to commit. A store that commits early still holds its slot until every older slot has been released.

Top module: `store_commit_sched`

## Requirements
- R1: After reset the ring is empty, `full` is low and `cm_valid` is low.
- R2: `full` is high while all DEPTH slots are in use. An allocation attempted while `full` is high is dropped: it never appears on the commit port. Slots are filled in ring order starting at slot 0 after reset.
- R3: A store is never offered for commit before its graduate pulse. Pulses mark stores graduated one at a time, in allocation order.
- R4: A half is offered only while its ownership bit is high. `own_ok[2*s+h]` belongs to slot s, half h, where h=0 is the line holding the start address and h=1 is the next line.
- R5: Among all candidate halves, the one in the oldest slot is offered, and within a slot half 0 comes before half 1. A younger ready store commits ahead of an older store whose line is not owned.
- R6: A fence entry blocks every younger store while any store older than the fence still has an uncommitted half.
- R7: A store that crosses a line boundary commits as two independent halves. Each half carries its own line address, mask and data.
- R8: A younger half that shares a byte (same line, overlapping mask) with an uncommitted half of an older store waits for that half. A younger half on the same line with a disjoint mask may commit first.
- R9: Slots are released only from the head. `full` stays high while the head is uncommitted, even after younger slots have committed.
- R10: The commit port gives the line address, a LINE_BYTES-bit byte mask and line-wide data. The store's bytes sit at the line offset of its address. A size code c means 2^c bytes.
- R11: A commit happens only when `cm_valid` and `cm_ready` are both high. While `cm_ready` is low the offered half stays pending and is offered again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_valid | input | 1 | Allocate a slot this cycle |
| alloc_addr | input | ADDR_W | Byte address of the store |
| alloc_size | input | SZ_W | Size code, 2^code bytes |
| alloc_data | input | 8*STORE_BYTES | Store data, least significant byte first |
| alloc_barrier | input | 1 | Entry is a fence, not a store |
| grad_pulse | input | 1 | Oldest ungraduated entry has retired |
| own_ok | input | 2*DEPTH | Write ownership held for the line of each slot half |
| cm_valid | output | 1 | A half is offered for commit |
| cm_ready | input | 1 | Cache accepts the offered half |
| cm_line | output | ADDR_W-log2(LINE_BYTES) | Line address of the offered half |
| cm_mask | output | LINE_BYTES | Byte enables within the line |
| cm_data | output | 8*LINE_BYTES | Line-aligned write data |
| full | output | 1 | All slots in use |

## Verification
The bench builds the block with DEPTH=4, 64-byte lines and 8-byte stores. With four slots the ring fills after a few allocations. The same test can then reach the dropped allocation, a head that blocks release behind younger committed slots, and the tail wrapping back to slot 0. The 64-byte line makes a 4-byte store at offset 63 split into a one-byte lower half and a three-byte upper half. This gives the split, overlap and fence orderings distinct expected commit sequences.

// File: rtl/sb_pkg.sv
package sb_pkg;
   // bytes written by a size code, clamped to the widest store
   function automatic int size_bytes(input int code, input int widest);
      int n;
      n = 1 << code;
      return (n > widest) ? widest : n;
   endfunction
endpackage

// File: rtl/sb_mask_gen.sv
module sb_mask_gen #(
   parameter int LINE_BYTES  = 64,
   parameter int STORE_BYTES = 8,
   localparam int OFF_W = $clog2(LINE_BYTES),
   localparam int SZ_W  = $clog2($clog2(STORE_BYTES) + 1),
   localparam int SPAN  = 2 * LINE_BYTES
) (
   input  logic [OFF_W-1:0] off,
   input  logic [SZ_W-1:0]  size,
   input  logic             barrier,
   output logic [SPAN-1:0]  span_mask
);
   always_comb begin
      logic [SPAN-1:0] run;
      run = (SPAN'(1) << sb_pkg::size_bytes(int'(size), STORE_BYTES)) - SPAN'(1);
      span_mask = barrier ? '0 : (run << off);
   end
endmodule

// File: rtl/sb_age_pick.sv
module sb_age_pick #(
   parameter int REQ = 16,
   localparam int IW = $clog2(REQ)
) (
   input  logic [REQ-1:0] req,
   input  logic [IW-1:0]  base,
   output logic           vld,
   output logic [IW-1:0]  idx
);
   // walk from youngest to oldest so the oldest request is written last
   always_comb begin
      logic [IW-1:0] s;
      vld = 1'b0;
      idx = base;
      for (int k = REQ - 1; k >= 0; k--) begin
         s = base + IW'(k);
         if (req[s]) begin
            vld = 1'b1;
            idx = s;
         end
      end
   end
endmodule

// File: rtl/store_commit_sched.sv
module store_commit_sched #(
   parameter int DEPTH       = 8,
   parameter int ADDR_W      = 32,
   parameter int LINE_BYTES  = 64,
   parameter int STORE_BYTES = 8,
   localparam int IDX_W  = $clog2(DEPTH),
   localparam int OFF_W  = $clog2(LINE_BYTES),
   localparam int LINE_W = ADDR_W - OFF_W,
   localparam int SZ_W   = $clog2($clog2(STORE_BYTES) + 1),
   localparam int CNT_W  = $clog2(DEPTH + 1),
   localparam int SPAN   = 2 * LINE_BYTES,
   localparam int SLOTS  = 2 * DEPTH
) (
   input  logic                      clk,
   input  logic                      rst,
   input  logic                      alloc_valid,
   input  logic [ADDR_W-1:0]         alloc_addr,
   input  logic [SZ_W-1:0]           alloc_size,
   input  logic [8*STORE_BYTES-1:0]  alloc_data,
   input  logic                      alloc_barrier,
   input  logic                      grad_pulse,
   input  logic [SLOTS-1:0]          own_ok,
   output logic                      cm_valid,
   input  logic                      cm_ready,
   output logic [LINE_W-1:0]         cm_line,
   output logic [LINE_BYTES-1:0]     cm_mask,
   output logic [8*LINE_BYTES-1:0]   cm_data,
   output logic                      full
);
   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("DEPTH must be a power of two, at least 2");
   end
   if ((LINE_BYTES & (LINE_BYTES - 1)) != 0 || STORE_BYTES > LINE_BYTES) begin : g_bad_line
      $error("LINE_BYTES must be a power of two no smaller than STORE_BYTES");
   end
   if ((STORE_BYTES & (STORE_BYTES - 1)) != 0) begin : g_bad_store
      $error("STORE_BYTES must be a power of two");
   end

   logic [DEPTH-1:0]         vld_q, grad_q, bar_q;
   logic [1:0]               done_q [DEPTH];
   logic [LINE_W-1:0]        line_q [DEPTH];
   logic [OFF_W-1:0]         off_q  [DEPTH];
   logic [SPAN-1:0]          mask_q [DEPTH];
   logic [8*STORE_BYTES-1:0] data_q [DEPTH];
   logic [IDX_W-1:0]         head_q, tail_q, gptr_q;
   logic [CNT_W-1:0]         cnt_q;

   logic [SPAN-1:0]          m_new;
   logic [SLOTS-1:0]         pend_v, ovl_blk, req;
   logic [DEPTH-1:0]         pend_any, fence_blk;
   logic [LINE_W-1:0]        hl [SLOTS];
   logic [LINE_BYTES-1:0]    hm [SLOTS];
   logic [IDX_W:0]           sel_slot;
   logic [IDX_W-1:0]         sel_ent;
   logic                     sel_half;
   logic                     fire, alloc_ok, grad_ok, free_ok;

   sb_mask_gen #(.LINE_BYTES(LINE_BYTES), .STORE_BYTES(STORE_BYTES)) u_mask (
      .off(alloc_addr[OFF_W-1:0]), .size(alloc_size),
      .barrier(alloc_barrier), .span_mask(m_new)
   );

   // per-half view of every slot: slot index = {entry, half}
   for (genvar e = 0; e < DEPTH; e++) begin : g_ent
      for (genvar h = 0; h < 2; h++) begin : g_half
         assign hl[2*e+h]     = line_q[e] + LINE_W'(h);
         assign hm[2*e+h]     = mask_q[e][h*LINE_BYTES +: LINE_BYTES];
         assign pend_v[2*e+h] = vld_q[e] & ~done_q[e][h];
         assign req[2*e+h]    = pend_v[2*e+h] & grad_q[e] & own_ok[2*e+h]
                                & ~fence_blk[e] & ~ovl_blk[2*e+h];
      end
      assign pend_any[e] = pend_v[2*e] | pend_v[2*e+1];
   end

   // age-ordered scan for fences and byte overlap with older pending halves
   always_comb begin
      logic [IDX_W-1:0] a, b;
      logic [IDX_W:0]   sa, sb;
      logic             pend_seen, fenced;
      fence_blk = '0;
      ovl_blk   = '0;
      pend_seen = 1'b0;
      fenced    = 1'b0;
      for (int k = 0; k < DEPTH; k++) begin
         a = head_q + IDX_W'(k);
         fence_blk[a] = fenced;
         for (int m = 0; m < k; m++) begin
            b = head_q + IDX_W'(m);
            for (int h = 0; h < 2; h++) begin
               for (int g = 0; g < 2; g++) begin
                  sa = {a, 1'(h)};
                  sb = {b, 1'(g)};
                  if (pend_v[sb] && hl[sb] == hl[sa] && (hm[sb] & hm[sa]) != '0)
                     ovl_blk[sa] = 1'b1;
               end
            end
         end
         if (vld_q[a] && bar_q[a] && pend_seen) fenced = 1'b1;
         if (pend_any[a]) pend_seen = 1'b1;
      end
   end

   sb_age_pick #(.REQ(SLOTS)) u_pick (
      .req(req), .base({head_q, 1'b0}), .vld(cm_valid), .idx(sel_slot)
   );

   assign sel_ent  = sel_slot[IDX_W:1];
   assign sel_half = sel_slot[0];
   assign cm_line  = hl[sel_slot];
   assign cm_mask  = hm[sel_slot];

   always_comb begin
      logic [8*SPAN-1:0] wide;
      wide = (8*SPAN)'(data_q[sel_ent]) << {off_q[sel_ent], 3'b000};
      cm_data = sel_half ? wide[8*SPAN-1 -: 8*LINE_BYTES] : wide[8*LINE_BYTES-1:0];
   end

   assign full     = (cnt_q == CNT_W'(DEPTH));
   assign fire     = cm_valid & cm_ready;
   assign alloc_ok = alloc_valid & ~full;
   assign grad_ok  = grad_pulse & vld_q[gptr_q] & ~grad_q[gptr_q];
   assign free_ok  = vld_q[head_q] & grad_q[head_q] & ~pend_any[head_q];

   always_ff @(posedge clk) begin
      if (rst) begin
         vld_q  <= '0;
         grad_q <= '0;
         bar_q  <= '0;
         head_q <= '0;
         tail_q <= '0;
         gptr_q <= '0;
         cnt_q  <= '0;
      end else begin
         if (fire) done_q[sel_ent][sel_half] <= 1'b1;
         if (grad_ok) begin
            grad_q[gptr_q] <= 1'b1;
            gptr_q         <= gptr_q + 1'b1;
         end
         if (free_ok) begin
            vld_q[head_q] <= 1'b0;
            head_q        <= head_q + 1'b1;
         end
         if (alloc_ok) begin
            vld_q[tail_q]  <= 1'b1;
            grad_q[tail_q] <= 1'b0;
            bar_q[tail_q]  <= alloc_barrier;
            line_q[tail_q] <= alloc_addr[ADDR_W-1:OFF_W];
            off_q[tail_q]  <= alloc_addr[OFF_W-1:0];
            mask_q[tail_q] <= m_new;
            data_q[tail_q] <= alloc_data;
            done_q[tail_q] <= {~|m_new[SPAN-1:LINE_BYTES], ~|m_new[LINE_BYTES-1:0]};
            tail_q         <= tail_q + 1'b1;
         end
         cnt_q <= cnt_q + CNT_W'(alloc_ok) - CNT_W'(free_ok);
      end
   end
endmodule

module store_commit_sched_chk #(
   parameter int DEPTH      = 8,
   parameter int LINE_BYTES = 64,
   localparam int IDX_W = $clog2(DEPTH),
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input logic                  clk,
   input logic                  rst,
   input logic                  cm_valid,
   input logic [LINE_BYTES-1:0] cm_mask,
   input logic [2*DEPTH-1:0]    own_ok,
   input logic                  full,
   input logic                  alloc_valid,
   input logic [IDX_W-1:0]      sel_ent,
   input logic                  sel_half,
   input logic [DEPTH-1:0]      grad_q,
   input logic [DEPTH-1:0]      vld_q,
   input logic [DEPTH-1:0]      pend_any,
   input logic [IDX_W-1:0]      head_q,
   input logic [CNT_W-1:0]      cnt_q
);
   // R10
   mask_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
      cm_valid |-> cm_mask != '0);
   // R4
   owned_line_chk: assert property (@(posedge clk) disable iff (rst)
      cm_valid |-> own_ok[{sel_ent, sel_half}]);
   // R3
   graduated_only_chk: assert property (@(posedge clk) disable iff (rst)
      cm_valid |-> grad_q[sel_ent]);
   // R2
   no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
      (full && alloc_valid) |=> cnt_q <= $past(cnt_q));
   // R9
   head_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (vld_q[head_q] && pend_any[head_q]) |=> head_q == $past(head_q));
endmodule

bind store_commit_sched store_commit_sched_chk #(.DEPTH(DEPTH), .LINE_BYTES(LINE_BYTES)) u_chk (
   .clk(clk), .rst(rst), .cm_valid(cm_valid), .cm_mask(cm_mask), .own_ok(own_ok),
   .full(full), .alloc_valid(alloc_valid), .sel_ent(sel_ent), .sel_half(sel_half),
   .grad_q(grad_q), .vld_q(vld_q), .pend_any(pend_any), .head_q(head_q), .cnt_q(cnt_q)
);

// File: tb/store_commit_sched_tb.sv
`timescale 1ns/1ps
module store_commit_sched_tb;
   localparam int D  = 4;
   localparam int AW = 32;
   localparam int LB = 64;
   localparam int SB = 8;
   localparam int LW = AW - 6;

   logic clk = 1'b0;
   logic rst;
   logic alloc_valid, alloc_barrier, grad_pulse, cm_ready;
   logic [AW-1:0] alloc_addr;
   logic [1:0] alloc_size;
   logic [8*SB-1:0] alloc_data;
   logic [2*D-1:0] own_ok;
   logic cm_valid, full;
   logic [LW-1:0] cm_line;
   logic [LB-1:0] cm_mask;
   logic [8*LB-1:0] cm_data;
   int n_run = 0, n_fail = 0;

   always #10 clk = ~clk;

   store_commit_sched #(.DEPTH(D), .ADDR_W(AW), .LINE_BYTES(LB), .STORE_BYTES(SB)) u_dut (
      .clk(clk), .rst(rst), .alloc_valid(alloc_valid), .alloc_addr(alloc_addr),
      .alloc_size(alloc_size), .alloc_data(alloc_data), .alloc_barrier(alloc_barrier),
      .grad_pulse(grad_pulse), .own_ok(own_ok), .cm_valid(cm_valid), .cm_ready(cm_ready),
      .cm_line(cm_line), .cm_mask(cm_mask), .cm_data(cm_data), .full(full)
   );

   task automatic chk(input string tag, input logic [8*LB-1:0] act, input logic [8*LB-1:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1; alloc_valid = 1'b0; alloc_barrier = 1'b0; grad_pulse = 1'b0;
      alloc_addr = '0; alloc_size = '0; alloc_data = '0; own_ok = '0; cm_ready = 1'b1;
      repeat (2) @(negedge clk);
      rst = 1'b0;
   endtask

   task automatic alloc(input int line, input int off, input int sz, input logic [63:0] d, input bit bar);
      alloc_valid = 1'b1; alloc_addr = {LW'(line), 6'(off)}; alloc_size = 2'(sz);
      alloc_data = d; alloc_barrier = bar;
      @(negedge clk);
      alloc_valid = 1'b0; alloc_barrier = 1'b0;
   endtask

   task automatic grad(input int n);
      grad_pulse = 1'b1;
      repeat (n) @(negedge clk);
      grad_pulse = 1'b0;
   endtask

   task automatic expect_none(input string tag);
      #1 chk({tag, " no commit"}, 512'(cm_valid), 512'(0));
   endtask

   // checks the offered half, then lets it commit on the next edge
   task automatic expect_commit(input string tag, input int line, input int off, input int sz,
                                input logic [63:0] d, input int half);
      logic [2*LB-1:0] one, m;
      logic [16*LB-1:0] w;
      one = 1;
      m = ((one << (1 << sz)) - one) << off;
      w = (16*LB)'(d) << (off * 8);
      #1;
      chk({tag, " valid"}, 512'(cm_valid), 512'(1));
      chk({tag, " line"}, 512'(cm_line), 512'(line + half));
      chk({tag, " mask"}, 512'(cm_mask), 512'(half ? m[2*LB-1:LB] : m[LB-1:0]));
      chk({tag, " data"}, cm_data, half ? w[16*LB-1:8*LB] : w[8*LB-1:0]);
      @(negedge clk);
   endtask

   task automatic t_reset();
      do_reset();
      #1;
      chk("R1 full", 512'(full), 512'(0));
      chk("R1 valid", 512'(cm_valid), 512'(0));
   endtask

   task automatic t_graduate_own();
      do_reset();
      own_ok = '1;
      alloc(1, 8, 3, 64'h1122334455667788, 0);
      expect_none("R3 before graduate");
      grad(1);
      expect_commit("R3 R10 after graduate", 1, 8, 3, 64'h1122334455667788, 0);
      own_ok = '0;
      alloc(2, 5, 1, 64'hBEEF, 0);
      grad(1);
      expect_none("R4 not owned");
      own_ok = 8'b0000_0100;
      expect_commit("R4 R10 owned", 2, 5, 1, 64'hBEEF, 0);
   endtask

   task automatic t_oldest_ready();
      do_reset();
      alloc(2, 0, 2, 64'hAAAA0001, 0);
      alloc(3, 4, 2, 64'hBBBB0002, 0);
      grad(2);
      own_ok = 8'b0000_0100;
      expect_commit("R5 younger ready first", 3, 4, 2, 64'hBBBB0002, 0);
      own_ok = 8'b0000_0101;
      expect_commit("R5 older later", 2, 0, 2, 64'hAAAA0001, 0);
      do_reset();
      alloc(10, 16, 0, 64'h5A, 0);
      alloc(11, 32, 0, 64'hA5, 0);
      grad(2);
      own_ok = '1;
      expect_commit("R5 both ready oldest", 10, 16, 0, 64'h5A, 0);
      expect_commit("R5 both ready next", 11, 32, 0, 64'hA5, 0);
   endtask

   task automatic t_barrier();
      do_reset();
      alloc(4, 0, 3, 64'hC0FFEE, 0);
      alloc(0, 0, 0, 64'h0, 1);
      alloc(5, 0, 3, 64'hD00D, 0);
      grad(3);
      own_ok = 8'b0001_0000;
      expect_none("R6 fence blocks");
      own_ok = 8'b0001_0001;
      expect_commit("R6 older first", 4, 0, 3, 64'hC0FFEE, 0);
      expect_commit("R6 released", 5, 0, 3, 64'hD00D, 0);
   endtask

   task automatic t_split();
      do_reset();
      alloc(6, 63, 2, 64'hA1B2C3D4, 0);
      grad(1);
      own_ok = 8'b0000_0010;
      expect_commit("R7 upper half alone", 6, 63, 2, 64'hA1B2C3D4, 1);
      expect_none("R7 lower waits");
      own_ok = 8'b0000_0011;
      expect_commit("R7 lower half", 6, 63, 2, 64'hA1B2C3D4, 0);
      expect_none("R7 done");
   endtask

   task automatic t_overlap();
      do_reset();
      alloc(8, 63, 2, 64'h01020304, 0);
      alloc(8, 60, 2, 64'h0A0B0C0D, 0);
      alloc(8, 0, 1, 64'h7788, 0);
      grad(3);
      own_ok = 8'b0001_0110;
      expect_commit("R8 split upper", 8, 63, 2, 64'h01020304, 1);
      expect_commit("R8 disjoint passes", 8, 0, 1, 64'h7788, 0);
      expect_none("R8 overlap waits");
      own_ok = 8'b0001_0111;
      expect_commit("R8 older lower", 8, 63, 2, 64'h01020304, 0);
      expect_commit("R8 overlap released", 8, 60, 2, 64'h0A0B0C0D, 0);
   endtask

   task automatic t_full_free();
      do_reset();
      for (int i = 0; i < D; i++) alloc(20 + i, 0, 3, 64'(i + 1), 0);
      #1 chk("R2 full", 512'(full), 512'(1));
      alloc(30, 0, 3, 64'hDEAD, 0);
      grad(D);
      own_ok = 8'b1111_1100;
      expect_commit("R9 slot1", 21, 0, 3, 64'd2, 0);
      expect_commit("R9 slot2", 22, 0, 3, 64'd3, 0);
      expect_commit("R9 slot3", 23, 0, 3, 64'd4, 0);
      #1 chk("R9 head holds full", 512'(full), 512'(1));
      own_ok = '1;
      expect_commit("R9 head", 20, 0, 3, 64'd1, 0);
      repeat (5) @(negedge clk);
      #1 chk("R9 freed", 512'(full), 512'(0));
      expect_none("R2 dropped alloc");
      alloc(31, 2, 1, 64'h4321, 0);
      grad(1);
      expect_commit("R2 wrap slot0", 31, 2, 1, 64'h4321, 0);
   endtask

   task automatic t_handshake();
      do_reset();
      own_ok = '1;
      cm_ready = 1'b0;
      alloc(40, 12, 2, 64'hFACE, 0);
      grad(1);
      #1 chk("R11 offered", 512'(cm_valid), 512'(1));
      @(negedge clk);
      #1 chk("R11 held line", 512'(cm_line), 512'(40));
      cm_ready = 1'b1;
      expect_commit("R11 accepted", 40, 12, 2, 64'hFACE, 0);
      expect_none("R11 single commit");
   endtask

   initial begin
      rst = 1'b1;
      t_reset();
      t_graduate_own();
      t_oldest_ready();
      t_barrier();
      t_split();
      t_overlap();
      t_full_free();
      t_handshake();
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_run++;
      n_fail++;
      $display("FAIL watchdog R1-all actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule